// File: doc/BRIEF.md
# Randomized memory request trace generator

This block takes the place of one processor core in front of a memory subsystem. A 32-bit LFSR is loaded from a seed input during reset. From that seed the block produces a reproducible stream of memory operations: plain loads, plain stores, load-reserved followed by store-conditional, atomic read-modify-write and fences. Each operation goes out on a request channel with a valid/ready handshake and carries an operation code, an address, store data, a request ID and a slot tag.

Responses come back tagged and may arrive in any order. The block matches each response to its request through a small table of outstanding slots. Every accepted request and every matched response produces one record on an event port, with the core ID, event kind, request ID, cycle stamp, address and value. An external consistency checker can rebuild the trace from these records. Store values never repeat, addresses come from a small pool that all cores share, and a sticky flag reports a response that has been awaited too long. After a set number of operations the block drains and signals completion.

Top module: `tg_core`

## Requirements
- R1: The LFSR is a 32-bit right-shifting Galois register with mask 0x80200003: when bit 0 is 1 the next state is (s>>1)^0x80200003, otherwise s>>1. It loads seed_i while rst_ni is low, and a seed of 0 is loaded as 1. It steps once for each generated request. The operation and the address index are read from the state before the step.
- R2: Unless an SC is owed, state bits [2:0] choose the operation: 0 or 1 load (code 0); 2, 3 or 7 store (code 1); 4 load-reserved (code 2); 5 atomic (code 4); 6 fence (code 5). The request generated right after a load-reserved is a store-conditional (code 3) to the same address.
- R3: Request IDs on req_id_o start at 0 after reset and rise by one per request. req_tag_o is the low log2(SLOTS) bits of the ID.
- R4: Store, store-conditional and atomic requests carry data {CORE_ID in the top CID_W bits, a per-core count in the low bits}. The count starts at 0 and rises by one per such request. Every other request carries data 0.
- R5: Unless an SC is owed, the address is ADDR_BASE + idx*ADDR_STRIDE, where idx is state bits [3+POOL_W-1:3].
- R6: While req_valid_o is high and req_ready_i is low, the request stays valid and all of its fields stay unchanged.
- R7: No request is issued while its tag slot is still outstanding, so at most SLOTS requests are in flight.
- R8: rsp_ready_o is low only in a cycle in which a request handshake completes. An accepted response whose tag slot is outstanding frees that slot and logs kind 3 with that request's ID and rsp_data_i as the value. A response on an idle tag logs nothing.
- R9: A request handshake logs, in the same cycle, kind 0 for load and load-reserved, kind 1 for store, store-conditional and atomic, or kind 2 for a fence, together with the request ID, address, data and evt_cycle_o. evt_cycle_o counts cycles from 0 in the first cycle after reset. evt_core_o is CORE_ID.
- R10: A fence is presented only when nothing is outstanding. No other request is issued until the fence's response is accepted.
- R11: timeout_o rises at the clock edge that ends the cycle in which an outstanding request has waited TIMEOUT cycles since its handshake, and it stays high until reset.
- R12: After NUM_OPS requests have been issued and all of their responses accepted, done_o goes high and stays high, and no further request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset; also loads the seed |
| seed_i | input | 32 | Trace seed |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Memory side accepts the request |
| req_op_o | output | 3 | Operation code |
| req_addr_o | output | ADDR_W | Request address |
| req_data_o | output | DATA_W | Store data |
| req_tag_o | output | log2(SLOTS) | Slot tag echoed by the response |
| req_id_o | output | ID_W | Per-core request ID |
| rsp_valid_i | input | 1 | Response valid |
| rsp_ready_o | output | 1 | Response accepted this cycle |
| rsp_tag_i | input | log2(SLOTS) | Tag of the response |
| rsp_data_i | input | DATA_W | Returned value |
| evt_valid_o | output | 1 | Log record valid |
| evt_kind_o | output | 2 | 0 load req, 1 store req, 2 fence req, 3 response |
| evt_core_o | output | CID_W | Core ID |
| evt_id_o | output | ID_W | Request ID |
| evt_cycle_o | output | CYC_W | Cycle stamp |
| evt_addr_o | output | ADDR_W | Address for requests, 0 for responses |
| evt_value_o | output | DATA_W | Store data or returned value |
| timeout_o | output | 1 | Sticky missing-response flag |
| done_o | output | 1 | All operations issued and drained |

## Verification
The assertions check on every cycle that the request fields hold steady while stalled and that a slot is never claimed twice. They also check that the LFSR never reaches zero, that a fence goes out only on an empty table and blocks the next cycle, and that completion implies an idle channel. The bench's scenarios are needed for everything else. They show that the exact operation sequence, addresses, IDs and unique store values follow the seed, that out-of-order responses are logged with the ID of the right request, that a response on an idle tag is ignored, and the exact cycle at which the missing-response flag rises.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LR    = 3'd2,
        OP_SC    = 3'd3,
        OP_AMO   = 3'd4,
        OP_FENCE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        EV_LOAD  = 2'd0,
        EV_STORE = 2'd1,
        EV_FENCE = 2'd2,
        EV_RESP  = 2'd3
    } ev_e;

    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

    function automatic op_e pick_op(input logic [2:0] sel);
        case (sel)
            3'd0, 3'd1:       return OP_LOAD;
            3'd2, 3'd3, 3'd7: return OP_STORE;
            3'd4:             return OP_LR;
            3'd5:             return OP_AMO;
            default:          return OP_FENCE;
        endcase
    endfunction

    function automatic logic writes_value(input op_e op);
        return (op == OP_STORE) || (op == OP_SC) || (op == OP_AMO);
    endfunction

    function automatic ev_e kind_of(input op_e op);
        if (op == OP_FENCE)  return EV_FENCE;
        if (writes_value(op)) return EV_STORE;
        return EV_LOAD;
    endfunction

endpackage

// File: rtl/tg_lfsr.sv
module tg_lfsr #(
    parameter int OUT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [31:0]      seed_i,
    input  logic             step_i,
    output logic [OUT_W-1:0] bits_o
);
    import tg_pkg::*;

    logic [31:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d = {1'b0, st_q[31:1]} ^ (st_q[0] ? LFSR_MASK : 32'h0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= (seed_i == 32'h0) ? 32'h1 : seed_i;
        else         st_q <= st_d;
    end

    assign bits_o = st_q[OUT_W-1:0];

    // R1: the generator state can never collapse to zero
    a_r1_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q != 32'h0);

endmodule

// File: rtl/tg_tag_table.sv
module tg_tag_table #(
    parameter int SLOTS   = 4,
    parameter int ID_W    = 16,
    parameter int CYC_W   = 32,
    parameter int TIMEOUT = 256,
    localparam int TAG_W  = $clog2(SLOTS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CYC_W-1:0] cycle_i,
    input  logic             alloc_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  logic [ID_W-1:0]  alloc_id_i,
    input  logic             free_i,
    input  logic [TAG_W-1:0] free_tag_i,
    output logic [SLOTS-1:0] busy_o,
    output logic             empty_o,
    output logic [ID_W-1:0]  free_id_o,
    output logic             timeout_o
);
    logic [SLOTS-1:0] busy_d, busy_q;
    logic [ID_W-1:0]  id_d  [SLOTS];
    logic [ID_W-1:0]  id_q  [SLOTS];
    logic [CYC_W-1:0] ts_d  [SLOTS];
    logic [CYC_W-1:0] ts_q  [SLOTS];
    logic [SLOTS-1:0] overdue;
    logic             tmo_d, tmo_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_age
        assign overdue[g] = busy_q[g] && ((cycle_i - ts_q[g]) >= CYC_W'(TIMEOUT));
    end

    always_comb begin
        busy_d = busy_q;
        id_d   = id_q;
        ts_d   = ts_q;
        if (alloc_i) begin
            busy_d[alloc_tag_i] = 1'b1;
            id_d[alloc_tag_i]   = alloc_id_i;
            ts_d[alloc_tag_i]   = cycle_i;
        end
        if (free_i) busy_d[free_tag_i] = 1'b0;
        tmo_d = tmo_q | (|overdue);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_q <= '0;
            tmo_q  <= 1'b0;
            for (int i = 0; i < SLOTS; i++) begin
                id_q[i] <= '0;
                ts_q[i] <= '0;
            end
        end else begin
            busy_q <= busy_d;
            id_q   <= id_d;
            ts_q   <= ts_d;
            tmo_q  <= tmo_d;
        end
    end

    assign busy_o    = busy_q;
    assign empty_o   = ~|busy_q;
    assign free_id_o = id_q[free_tag_i];
    assign timeout_o = tmo_q;

    // R7: a slot is claimed only while it is idle
    a_r7_alloc_idle_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_i |-> !busy_q[alloc_tag_i]);

endmodule

// File: rtl/tg_core.sv
module tg_core #(
    parameter int          CORE_ID     = 0,
    parameter int          CID_W       = 4,
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] ADDR_BASE   = 32'h0000_1000,
    parameter logic [31:0] ADDR_STRIDE = 32'h0000_0040,
    parameter int          POOL_W      = 2,
    parameter int          SLOTS       = 4,
    parameter int          ID_W        = 16,
    parameter int          CYC_W       = 32,
    parameter int          NUM_OPS     = 64,
    parameter int          TIMEOUT     = 256,
    localparam int         TAG_W       = $clog2(SLOTS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [31:0]       seed_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [2:0]        req_op_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_data_o,
    output logic [TAG_W-1:0]  req_tag_o,
    output logic [ID_W-1:0]   req_id_o,
    input  logic              rsp_valid_i,
    output logic              rsp_ready_o,
    input  logic [TAG_W-1:0]  rsp_tag_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              evt_valid_o,
    output logic [1:0]        evt_kind_o,
    output logic [CID_W-1:0]  evt_core_o,
    output logic [ID_W-1:0]   evt_id_o,
    output logic [CYC_W-1:0]  evt_cycle_o,
    output logic [ADDR_W-1:0] evt_addr_o,
    output logic [DATA_W-1:0] evt_value_o,
    output logic              timeout_o,
    output logic              done_o
);
    import tg_pkg::*;

    localparam int RND_W = 3 + POOL_W;
    localparam int CNT_W = DATA_W - CID_W;
    localparam int ISS_W = $clog2(NUM_OPS + 1);

    typedef struct packed {
        logic              req_valid;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [ID_W-1:0]   req_id;
        logic [ID_W-1:0]   next_id;
        logic [CNT_W-1:0]  store_cnt;
        logic              sc_pend;
        logic [ADDR_W-1:0] sc_addr;
        logic [ISS_W-1:0]  issued;
        logic              fence_out;
        logic [CYC_W-1:0]  cycle;
        logic              done;
    } state_t;

    state_t s_d, s_q;

    logic [RND_W-1:0] rnd;
    logic [SLOTS-1:0] busy;
    logic             tbl_empty;
    logic [ID_W-1:0]  rsp_id;
    logic             fire, rsp_hit, gen;
    op_e              gen_op;
    logic [ADDR_W-1:0] gen_addr;

    tg_lfsr #(.OUT_W(RND_W)) u_lfsr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .seed_i (seed_i),
        .step_i (gen),
        .bits_o (rnd)
    );

    tg_tag_table #(
        .SLOTS(SLOTS), .ID_W(ID_W), .CYC_W(CYC_W), .TIMEOUT(TIMEOUT)
    ) u_table (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cycle_i     (s_q.cycle),
        .alloc_i     (fire),
        .alloc_tag_i (s_q.req_id[TAG_W-1:0]),
        .alloc_id_i  (s_q.req_id),
        .free_i      (rsp_hit),
        .free_tag_i  (rsp_tag_i),
        .busy_o      (busy),
        .empty_o     (tbl_empty),
        .free_id_o   (rsp_id),
        .timeout_o   (timeout_o)
    );

    always_comb begin
        s_d       = s_q;
        s_d.cycle = s_q.cycle + 1'b1;

        fire    = s_q.req_valid && req_ready_i;
        rsp_hit = rsp_valid_i && !fire && busy[rsp_tag_i];

        gen_op   = s_q.sc_pend ? OP_SC : pick_op(rnd[2:0]);
        gen_addr = s_q.sc_pend ? s_q.sc_addr
                 : ADDR_W'(ADDR_BASE) + ADDR_W'(ADDR_STRIDE) * ADDR_W'(rnd[RND_W-1:3]);

        gen = !s_q.req_valid && (s_q.issued < ISS_W'(NUM_OPS)) && !s_q.fence_out
              && !busy[s_q.next_id[TAG_W-1:0]]
              && ((gen_op != OP_FENCE) || tbl_empty);

        if (fire) begin
            s_d.req_valid = 1'b0;
            if (s_q.op == OP_FENCE) s_d.fence_out = 1'b1;
        end
        if (s_q.fence_out && tbl_empty) s_d.fence_out = 1'b0;

        if (gen) begin
            s_d.req_valid = 1'b1;
            s_d.op        = gen_op;
            s_d.addr      = gen_addr;
            s_d.req_id    = s_q.next_id;
            s_d.next_id   = s_q.next_id + 1'b1;
            s_d.issued    = s_q.issued + 1'b1;
            s_d.sc_pend   = (gen_op == OP_LR);
            if (gen_op == OP_LR) s_d.sc_addr = gen_addr;
            if (writes_value(gen_op)) begin
                s_d.data      = {CID_W'(CORE_ID), s_q.store_cnt};
                s_d.store_cnt = s_q.store_cnt + 1'b1;
            end else begin
                s_d.data = '0;
            end
        end

        s_d.done = s_q.done
                 | ((s_q.issued == ISS_W'(NUM_OPS)) && !s_q.req_valid && tbl_empty);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.op <= OP_LOAD;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid_o = s_q.req_valid;
    assign req_op_o    = s_q.op;
    assign req_addr_o  = s_q.addr;
    assign req_data_o  = s_q.data;
    assign req_tag_o   = s_q.req_id[TAG_W-1:0];
    assign req_id_o    = s_q.req_id;
    assign rsp_ready_o = !fire;
    assign done_o      = s_q.done;

    assign evt_valid_o = fire || rsp_hit;
    assign evt_core_o  = CID_W'(CORE_ID);
    assign evt_cycle_o = s_q.cycle;
    assign evt_kind_o  = fire ? kind_of(s_q.op) : EV_RESP;
    assign evt_id_o    = fire ? s_q.req_id : rsp_id;
    assign evt_addr_o  = fire ? s_q.addr : '0;
    assign evt_value_o = fire ? s_q.data : rsp_data_i;

    // R6: a stalled request keeps its contents
    a_r6_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_op_o)
            && $stable(req_addr_o) && $stable(req_data_o) && $stable(req_id_o));

    // R10: a fence is offered only with nothing in flight
    a_r10_fence_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o && (req_op_o == OP_FENCE) |-> tbl_empty);

    // R10: nothing follows a fence on the next cycle
    a_r10_fence_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o && req_ready_i && (req_op_o == OP_FENCE) |=> !req_valid_o);

    // R12: completion means an idle channel and an empty table
    a_r12_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !req_valid_o && tbl_empty);

endmodule

// File: tb/tg_core_bench.sv
module tg_core_bench;
    localparam int          CORE_ID = 5;
    localparam int          CID_W   = 4;
    localparam int          DATA_W  = 32;
    localparam int          ADDR_W  = 32;
    localparam logic [31:0] BASE    = 32'h0000_0100;
    localparam logic [31:0] STRIDE  = 32'h0000_0008;
    localparam int          POOL_W  = 2;
    localparam int          SLOTS   = 4;
    localparam int          ID_W    = 16;
    localparam int          CYC_W   = 32;
    localparam int          NUM_OPS = 100;
    localparam int          TMO     = 40;
    localparam int          TAG_W   = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [31:0]       seed = 32'h1;
    logic              req_valid, req_ready = 1'b0;
    logic [2:0]        req_op;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic [TAG_W-1:0]  req_tag;
    logic [ID_W-1:0]   req_id;
    logic              rsp_valid = 1'b0, rsp_ready;
    logic [TAG_W-1:0]  rsp_tag = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              evt_valid;
    logic [1:0]        evt_kind;
    logic [CID_W-1:0]  evt_core;
    logic [ID_W-1:0]   evt_id;
    logic [CYC_W-1:0]  evt_cycle;
    logic [ADDR_W-1:0] evt_addr;
    logic [DATA_W-1:0] evt_value;
    logic              timeout, done;

    tg_core #(
        .CORE_ID(CORE_ID), .CID_W(CID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .ADDR_BASE(BASE), .ADDR_STRIDE(STRIDE), .POOL_W(POOL_W), .SLOTS(SLOTS),
        .ID_W(ID_W), .CYC_W(CYC_W), .NUM_OPS(NUM_OPS), .TIMEOUT(TMO)
    ) u_tg_core (
        .clk_i(clk), .rst_ni(rst_n), .seed_i(seed),
        .req_valid_o(req_valid), .req_ready_i(req_ready), .req_op_o(req_op),
        .req_addr_o(req_addr), .req_data_o(req_data), .req_tag_o(req_tag),
        .req_id_o(req_id), .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready),
        .rsp_tag_i(rsp_tag), .rsp_data_i(rsp_data), .evt_valid_o(evt_valid),
        .evt_kind_o(evt_kind), .evt_core_o(evt_core), .evt_id_o(evt_id),
        .evt_cycle_o(evt_cycle), .evt_addr_o(evt_addr), .evt_value_o(evt_value),
        .timeout_o(timeout), .done_o(done)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] bcyc = 0;
    always @(posedge clk) bcyc <= rst_n ? bcyc + 1 : 32'h0;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lstep(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    function automatic int op_from(input logic [2:0] sel);
        case (sel)
            3'd0, 3'd1:       return 0;
            3'd2, 3'd3, 3'd7: return 1;
            3'd4:             return 2;
            3'd5:             return 4;
            default:          return 5;
        endcase
    endfunction

    task automatic run(input logic [31:0] s, input bit no_rsp);
        logic [31:0] m_l;
        bit          m_sc;
        logic [31:0] m_sc_addr;
        int          m_cnt, m_id, m_iss;
        bit          pv [SLOTS];
        int          pid [SLOTS];
        int          pop [SLOTS];
        bit          fence_wait, hold, finished;
        int          h_op, h_id, first, nout;
        logic [31:0] h_addr, h_data;

        m_l = (s == 0) ? 32'h1 : s;
        m_sc = 0; m_sc_addr = 0; m_cnt = 0; m_id = 0; m_iss = 0;
        fence_wait = 0; hold = 0; finished = 0; first = -1;
        h_op = 0; h_id = 0; h_addr = 0; h_data = 0;
        for (int i = 0; i < SLOTS; i++) begin pv[i] = 0; pid[i] = 0; pop[i] = 0; end

        @(negedge clk);
        rst_n = 0; seed = s; req_ready = 0; rsp_valid = 0;
        repeat (3) @(negedge clk);
        chk(!req_valid && !done && !timeout && !evt_valid, "reset R12", {req_valid, done, timeout}, 0);
        rst_n = 1;

        for (int k = 0; k < 20000 && !finished; k++) begin
            @(negedge clk);
            req_ready = no_rsp ? 1'b1 : (($urandom % 4) != 0);
            rsp_valid = 0;
            if (!no_rsp && ($urandom % 2 == 0)) begin
                int st;
                st = $urandom % SLOTS;
                for (int j = 0; j < SLOTS; j++) begin
                    if (!rsp_valid && pv[(st + j) % SLOTS]) begin
                        rsp_valid = 1;
                        rsp_tag   = TAG_W'((st + j) % SLOTS);
                        rsp_data  = $urandom;
                    end
                end
            end
            #1;
            if (hold) begin
                chk(req_valid && req_op == 3'(h_op) && req_id == ID_W'(h_id)
                    && req_addr == h_addr && req_data == h_data, "R6 stalled hold", req_id, h_id);
                hold = 0;
            end
            if (rsp_valid && rsp_ready) begin
                chk(evt_valid && evt_kind == 2'd3, "R8 response event", {evt_valid, evt_kind}, 7);
                chk(evt_id == ID_W'(pid[rsp_tag]), "R8 response id", evt_id, pid[rsp_tag]);
                chk(evt_value == rsp_data, "R8 response value", evt_value, rsp_data);
                if (pop[rsp_tag] == 5) fence_wait = 0;
                pv[rsp_tag] = 0;
            end
            if (req_valid && !req_ready) begin
                hold = 1; h_op = int'(req_op); h_id = int'(req_id);
                h_addr = req_addr; h_data = req_data;
            end
            if (req_valid && req_ready) begin
                int eop, ekind;
                logic [31:0] eaddr, edata;
                nout = 0;
                for (int j = 0; j < SLOTS; j++) nout += pv[j];
                chk(!rsp_ready, "R8 ready low on issue", rsp_ready, 0);
                chk(!fence_wait, "R10 issue behind fence", fence_wait, 0);
                if (m_sc) begin
                    eop = 3; eaddr = m_sc_addr; m_sc = 0;
                end else begin
                    eop = op_from(m_l[2:0]);
                    eaddr = BASE + STRIDE * 32'(m_l[4:3]);
                    if (eop == 2) begin m_sc = 1; m_sc_addr = eaddr; end
                end
                m_l = lstep(m_l);
                if (eop == 1 || eop == 3 || eop == 4) begin
                    edata = {4'(CORE_ID), 28'(m_cnt)}; m_cnt++;
                end else edata = 0;
                ekind = (eop == 5) ? 2 : ((eop == 1 || eop == 3 || eop == 4) ? 1 : 0);
                chk(req_op == 3'(eop), "R1 R2 operation", req_op, eop);
                chk(req_addr == eaddr, "R5 address", req_addr, eaddr);
                chk(req_data == edata, "R4 store value", req_data, edata);
                chk(req_id == ID_W'(m_id) && req_tag == TAG_W'(m_id), "R3 id and tag", req_id, m_id);
                chk(!pv[req_tag], "R7 slot free", pv[req_tag], 0);
                if (eop == 5) begin
                    chk(nout == 0, "R10 fence drained", nout, 0);
                    fence_wait = 1;
                end
                chk(evt_valid && evt_kind == 2'(ekind), "R9 kind", evt_kind, ekind);
                chk(evt_id == req_id && evt_addr == eaddr && evt_value == edata
                    && evt_core == 4'(CORE_ID), "R9 fields", evt_id, m_id);
                chk(evt_cycle == bcyc, "R9 cycle", evt_cycle, bcyc);
                pv[req_tag] = 1; pid[req_tag] = m_id; pop[req_tag] = eop;
                m_id++; m_iss++;
                if (first < 0) first = k;
            end
            if (no_rsp && first >= 0) begin
                if (k == first + TMO) chk(timeout == 0, "R11 not yet", timeout, 0);
                if (k == first + TMO + 1) begin
                    chk(timeout == 1, "R11 raised", timeout, 1);
                    finished = 1;
                end
            end
            if (!no_rsp && done) finished = 1;
        end
        rsp_valid = 0;
        chk(finished, "R12 run completes", finished, 1);
        if (!no_rsp) begin
            chk(m_iss == NUM_OPS, "R12 issued count", m_iss, NUM_OPS);
            @(negedge clk);
            rsp_valid = 1; rsp_tag = 2'd1; rsp_data = 32'hDEAD_BEEF;
            #1;
            chk(!evt_valid, "R8 idle tag ignored", evt_valid, 0);
            chk(done && !req_valid, "R12 done holds", {done, req_valid}, 2);
            @(negedge clk);
            rsp_valid = 0;
            #1;
            chk(done && !req_valid, "R12 done sticky", {done, req_valid}, 2);
        end
    endtask

    initial begin
        run(32'h0000_ACE1, 0);
        run(32'h0, 0);
        run(32'h1234_5678, 0);
        run(32'h0000_0009, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule